// File: doc/BRIEF.md
# Overlapped Accumulator CPU Core

This block is a small 8-bit accumulator processor. It runs a compact instruction subset: add-with-carry of an immediate, exclusive-or of an immediate, load and store of a zero-page byte, and four operations that only touch internal state (clear carry, set carry, shift left, shift right). Every clock makes exactly one access on a single byte-wide memory bus. The address is driven during the cycle, read data is expected back in the same cycle, and a write takes place at the closing clock edge when the write strobe is high.

The core overlaps fetch and execute. The opcode is decoded in the cycle that reads the operand byte. The arithmetic for an immediate or register-only instruction is not given a cycle of its own. Its result, with the carry, is written into the accumulator during the opcode fetch of the next instruction. This means a two-byte immediate instruction costs two bus cycles. Zero page is the 256-byte region whose upper address byte is zero. It is reached through a single operand byte and serves as a store that behaves much like a register file.

The memory port is a plain synchronous bus with no valid/ready handshake. The core issues one access every cycle and never waits, so the memory must answer combinationally in the same cycle. The debug outputs show the committed accumulator and the program counter.

Top module: `acc_core`

## Requirements
- R1: While reset is held, the program counter reads 0x0200, the accumulator reads 0, the carry is clear and the write strobe is low. The first cycle after reset fetches an opcode from 0x0200.
- R2: Opcode 0x10 (add with carry, immediate) takes exactly 2 bus cycles: the opcode read at PC, then the operand read at PC+1. Its result is accumulator + operand + carry, and the carry becomes bit 8 of the sum. During the opcode and operand cycles, dbg_pc equals the bus address.
- R3: The result of an immediate or register-only instruction stays off dbg_acc through the next instruction's opcode fetch cycle. It appears in the cycle after that fetch, together with the new carry.
- R4: An instruction that follows an arithmetic instruction sees the new accumulator and carry. A store writes the new sum, and a chained add uses the new carry.
- R5: Opcode 0x11 (exclusive-or, immediate) takes 2 cycles. It produces accumulator XOR operand and leaves the carry unchanged.
- R6: Opcode 0x20 (zero-page load) takes 3 cycles. The third cycle reads address {0x00, operand} with the strobe low, and the loaded byte shows on dbg_acc from the next cycle on.
- R7: Opcode 0x21 (zero-page store) takes 3 cycles. The strobe is high only in the third cycle, with address {0x00, operand} and write data equal to the accumulator.
- R8: Opcodes 0x30 (clear carry), 0x31 (set carry), 0x32 (shift left, bit 7 into carry, 0 into bit 0) and 0x33 (shift right, bit 0 into carry, 0 into bit 7) each take 2 cycles. Their second cycle reads PC without advancing it, and the result is committed as in R3.
- R9: Any other opcode takes 2 cycles, advances PC by 1 and leaves the accumulator and carry unchanged.
- R10: A zero-page load followed by a store to the same address takes 6 cycles in total. The next opcode fetch starts in the seventh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW (16) | Bus address for this cycle |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_we | output | 1 | Write strobe; the write happens at the clock edge that ends the cycle |
| dbg_acc | output | 8 | Committed accumulator |
| dbg_pc | output | AW (16) | Program counter |

## Verification
The in-RTL properties check rules that hold on every cycle. A zero-page access is always followed by an opcode fetch. An immediate instruction advances PC by one and then returns to fetch, while register-only and unknown opcodes hold PC. The accumulator never changes at the end of an operand cycle, and any pending result is drained by each fetch. The write strobe appears only with a zero-page address. The data values themselves can only be shown by the bench's scenarios: the carry chain across adds, the sum a store writes right after an add, the shift results, and the exact cycle in which each result first appears.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int DATA_W = 8;

  localparam logic [7:0] OPC_ADDC_IMM = 8'h10;
  localparam logic [7:0] OPC_XOR_IMM  = 8'h11;
  localparam logic [7:0] OPC_LOAD_ZP  = 8'h20;
  localparam logic [7:0] OPC_STORE_ZP = 8'h21;
  localparam logic [7:0] OPC_CLR_C    = 8'h30;
  localparam logic [7:0] OPC_SET_C    = 8'h31;
  localparam logic [7:0] OPC_SHL_A    = 8'h32;
  localparam logic [7:0] OPC_SHR_A    = 8'h33;

  typedef enum logic [1:0] {ST_FETCH, ST_OPER, ST_ZP} phase_t;
  typedef enum logic [2:0] {K_NOP, K_ALU_IMM, K_REG, K_LOAD, K_STORE} kind_t;
  typedef enum logic [2:0] {OP_ADDC, OP_XOR, OP_CLRC, OP_SETC, OP_SHL, OP_SHR} alu_op_t;

  typedef struct packed {
    kind_t   kind;
    alu_op_t op;
  } decoded_t;
endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
(
  input  logic [7:0] opcode,
  output decoded_t   dec
);
  always_comb begin
    dec.kind = K_NOP;
    dec.op   = OP_ADDC;
    case (opcode)
      OPC_ADDC_IMM: begin dec.kind = K_ALU_IMM; dec.op = OP_ADDC; end
      OPC_XOR_IMM:  begin dec.kind = K_ALU_IMM; dec.op = OP_XOR;  end
      OPC_LOAD_ZP:  dec.kind = K_LOAD;
      OPC_STORE_ZP: dec.kind = K_STORE;
      OPC_CLR_C:    begin dec.kind = K_REG; dec.op = OP_CLRC; end
      OPC_SET_C:    begin dec.kind = K_REG; dec.op = OP_SETC; end
      OPC_SHL_A:    begin dec.kind = K_REG; dec.op = OP_SHL;  end
      OPC_SHR_A:    begin dec.kind = K_REG; dec.op = OP_SHR;  end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_t      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);
  always_comb begin
    y    = a;
    cout = cin;
    case (op)
      OP_ADDC: {cout, y} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      OP_XOR:  y = a ^ b;
      OP_CLRC: cout = 1'b0;
      OP_SETC: cout = 1'b1;
      OP_SHL:  {cout, y} = {a, 1'b0};
      OP_SHR:  {y, cout} = {1'b0, a};
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_core_seq.sv
module acc_core_seq
  import acc_core_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] RESET_PC = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  kind_t         kind,
  input  logic [DW-1:0] rdata,
  output phase_t        phase,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] addr,
  output logic          we
);
  localparam int ZP_HI = AW - DW;
  localparam logic [AW-1:0] ONE = 1;

  logic [DW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= ST_FETCH;
      pc    <= RESET_PC;
      ir    <= '0;
      ptr   <= '0;
    end else begin
      case (phase)
        ST_FETCH: begin
          ir    <= rdata;
          pc    <= pc + ONE;
          phase <= ST_OPER;
        end
        ST_OPER: begin
          case (kind)
            K_ALU_IMM: begin
              pc    <= pc + ONE;
              phase <= ST_FETCH;
            end
            K_LOAD, K_STORE: begin
              ptr   <= rdata;
              pc    <= pc + ONE;
              phase <= ST_ZP;
            end
            default: phase <= ST_FETCH;
          endcase
        end
        default: phase <= ST_FETCH;
      endcase
    end
  end

  assign addr = (phase == ST_ZP) ? {{ZP_HI{1'b0}}, ptr} : pc;
  assign we   = (phase == ST_ZP) && (kind == K_STORE);

  assert_zp_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == ST_ZP |=> phase == ST_FETCH);
  assert_imm_two_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_OPER && kind == K_ALU_IMM) |=> (phase == ST_FETCH && pc == $past(pc) + ONE));
  assert_reg_holds_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_OPER && (kind == K_REG || kind == K_NOP)) |=> (phase == ST_FETCH && $stable(pc)));
  assert_strobe_in_zp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> addr[AW-1:DW] == '0);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_PC = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [AW-1:0]     mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] dbg_acc,
  output logic [AW-1:0]     dbg_pc
);
  phase_t            phase;
  logic [AW-1:0]     pc;
  logic [DATA_W-1:0] ir;
  decoded_t          dec;

  logic [DATA_W-1:0] acc;
  logic              carry;
  logic              pend_v;
  alu_op_t           pend_op;
  logic [DATA_W-1:0] pend_b;
  logic [DATA_W-1:0] alu_y;
  logic              alu_c;

  acc_core_decode u_dec (
    .opcode (ir),
    .dec    (dec)
  );

  acc_core_seq #(.AW(AW), .DW(DATA_W), .RESET_PC(RESET_PC)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .kind  (dec.kind),
    .rdata (mem_rdata),
    .phase (phase),
    .pc    (pc),
    .ir    (ir),
    .addr  (mem_addr),
    .we    (mem_we)
  );

  acc_core_alu #(.W(DATA_W)) u_alu (
    .op   (pend_op),
    .a    (acc),
    .b    (pend_b),
    .cin  (carry),
    .y    (alu_y),
    .cout (alu_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      carry   <= 1'b0;
      pend_v  <= 1'b0;
      pend_op <= OP_ADDC;
      pend_b  <= '0;
    end else begin
      if (phase == ST_FETCH && pend_v) begin
        acc    <= alu_y;
        carry  <= alu_c;
        pend_v <= 1'b0;
      end
      if (phase == ST_OPER && (dec.kind == K_ALU_IMM || dec.kind == K_REG)) begin
        pend_v  <= 1'b1;
        pend_op <= dec.op;
        pend_b  <= mem_rdata;
      end
      if (phase == ST_ZP && dec.kind == K_LOAD) acc <= mem_rdata;
    end
  end

  assign mem_wdata = acc;
  assign dbg_acc   = acc;
  assign dbg_pc    = pc;

  assert_no_commit_in_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == ST_OPER |=> $stable(acc) && $stable(carry));
  assert_fetch_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == ST_FETCH |=> !pend_v);
  assert_nop_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_OPER && dec.kind == K_NOP) |=> (phase == ST_FETCH && !pend_v));
endmodule

// File: tb/acc_core_test.sv
module acc_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata, dbg_acc;
  logic        mem_we;
  logic [15:0] dbg_pc;

  logic [7:0] zp   [0:255];
  logic [7:0] prog [0:255];

  int checks = 0;
  int fails  = 0;

  logic [15:0] q_addr[$];
  logic        q_we[$];
  logic [7:0]  q_wd[$];
  logic [7:0]  q_acc[$];
  logic [15:0] q_pc[$];
  string       q_tag[$];

  acc_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .dbg_acc(dbg_acc), .dbg_pc(dbg_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = (mem_addr[15:8] == 8'h00) ? zp[mem_addr[7:0]] :
                     (mem_addr[15:8] == 8'h02) ? prog[mem_addr[7:0]] : 8'hFF;

  always @(posedge clk) if (mem_we && mem_addr[15:8] == 8'h00) zp[mem_addr[7:0]] <= mem_wdata;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] code_at(input logic [15:0] a);
    return (a[15:8] == 8'h02) ? prog[a[7:0]] : 8'hFF;
  endfunction

  task automatic push(input logic [15:0] a, input logic w, input logic [7:0] wd,
                      input logic [7:0] ac, input logic [15:0] p, input string tag);
    q_addr.push_back(a); q_we.push_back(w); q_wd.push_back(wd);
    q_acc.push_back(ac); q_pc.push_back(p); q_tag.push_back(tag);
  endtask

  // Behavioural reference: walks the program one instruction at a time
  // and lists what every bus cycle should show.
  task automatic build_model(input int n_instr);
    logic [7:0]  m_acc = 8'h00, mz [0:255], op, pk = 8'h00, pb = 8'h00, ptr;
    logic        m_c = 1'b0, pv = 1'b0, prev_alu = 1'b0;
    logic [15:0] m_pc = 16'h0200;
    logic [8:0]  s;
    string       t;
    for (int i = 0; i < 256; i++) mz[i] = zp[i];
    for (int n = 0; n < n_instr; n++) begin
      op = code_at(m_pc);
      case (op)
        8'h10: t = "R2";
        8'h11: t = "R5";
        8'h20: t = "R6";
        8'h21: t = "R7";
        8'h30, 8'h31, 8'h32, 8'h33: t = "R8";
        default: t = "R9";
      endcase
      push(m_pc, 1'b0, 8'h00, m_acc, m_pc, pv ? "R3" : t);
      if (pv) begin
        case (pk)
          8'h10: begin s = {1'b0, m_acc} + {1'b0, pb} + {8'h00, m_c}; m_acc = s[7:0]; m_c = s[8]; end
          8'h11: m_acc = m_acc ^ pb;
          8'h30: m_c = 1'b0;
          8'h31: m_c = 1'b1;
          8'h32: begin m_c = m_acc[7]; m_acc = {m_acc[6:0], 1'b0}; end
          8'h33: begin m_c = m_acc[0]; m_acc = {1'b0, m_acc[7:1]}; end
          default: ;
        endcase
        pv = 1'b0;
      end
      m_pc = m_pc + 16'd1;
      push(m_pc, 1'b0, 8'h00, m_acc, m_pc, t);
      case (op)
        8'h10, 8'h11: begin pv = 1'b1; pk = op; pb = code_at(m_pc); m_pc = m_pc + 16'd1; end
        8'h20: begin
          ptr = code_at(m_pc); m_pc = m_pc + 16'd1;
          push({8'h00, ptr}, 1'b0, 8'h00, m_acc, m_pc, "R6");
          m_acc = mz[ptr];
        end
        8'h21: begin
          ptr = code_at(m_pc); m_pc = m_pc + 16'd1;
          push({8'h00, ptr}, 1'b1, m_acc, m_acc, m_pc, prev_alu ? "R4" : "R7");
          mz[ptr] = m_acc;
        end
        8'h30, 8'h31, 8'h32, 8'h33: begin pv = 1'b1; pk = op; end
        default: ;
      endcase
      prev_alu = (op == 8'h10 || op == 8'h11 || (op >= 8'h30 && op <= 8'h33));
    end
  endtask

  task automatic run(input int n_instr, input int probe_cyc, input logic [15:0] probe_pc);
    int cyc = 0;
    build_model(n_instr);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(dbg_pc == 16'h0200, "R1", "reset pc", dbg_pc, 16'h0200);
    check(dbg_acc == 8'h00 && !mem_we, "R1", "reset acc/we", {dbg_acc, 7'b0, mem_we}, 0);
    rst_n = 1'b1;
    while (q_addr.size() > 0) begin
      #1;
      check(mem_addr == q_addr[0] && mem_we == q_we[0], q_tag[0], "addr/we",
            {mem_addr, 15'b0, mem_we}, {q_addr[0], 15'b0, q_we[0]});
      check(dbg_acc == q_acc[0] && dbg_pc == q_pc[0], q_tag[0], "acc/pc",
            {dbg_acc, dbg_pc}, {q_acc[0], q_pc[0]});
      if (q_we[0]) check(mem_wdata == q_wd[0], q_tag[0], "wdata", mem_wdata, q_wd[0]);
      if (cyc == probe_cyc)
        check(mem_addr == probe_pc && dbg_pc == probe_pc, "R10", "next fetch", mem_addr, probe_pc);
      void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_wd.pop_front());
      void'(q_acc.pop_front()); void'(q_pc.pop_front()); void'(q_tag.pop_front());
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic load_prog(input logic [7:0] bytes[$]);
    for (int i = 0; i < 256; i++) prog[i] = 8'hFF;
    for (int i = 0; i < bytes.size(); i++) prog[i] = bytes[i];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) zp[i] = 8'(i * 7 + 3);
    // Arithmetic chain with carry, store right after add, flag and shift ops
    load_prog('{8'h10, 8'h05, 8'h10, 8'hFF, 8'h10, 8'h00, 8'h21, 8'h10,
                8'h11, 8'h0F, 8'h31, 8'h10, 8'h01, 8'h32, 8'h33, 8'h30,
                8'h20, 8'h10, 8'h10, 8'h80, 8'h10, 8'h80, 8'h21, 8'h11});
    run(20, -1, 16'h0000);
    // Load then store to one address: next fetch at 0x0204 in cycle 6
    zp[8'h40] = 8'h5A;
    load_prog('{8'h20, 8'h40, 8'h21, 8'h40, 8'h10, 8'h01, 8'h21, 8'h41});
    run(6, 6, 16'h0204);
    check(zp[8'h41] == 8'h5B, "R4", "zp store after add", zp[8'h41], 8'h5B);
    // Unknown opcodes and shifts that push bits into carry
    load_prog('{8'h11, 8'h81, 8'h00, 8'hAB, 8'h32, 8'h7F, 8'h10, 8'h00,
                8'h33, 8'h10, 8'h00, 8'h31, 8'h12, 8'h21, 8'h20});
    run(14, -1, 16'h0000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule